// File: doc/BRIEF.md
# Late-Write Burst-of-Two SRAM Core

This block is the synchronous storage and control logic of a double-data-rate static RAM that moves every access as a burst of two words over one shared data bus. It runs on a single internal clock at twice the command rate, so each data phase has its own rising edge. The block generates its own phase. The `k_edge` output is high when the next rising clock edge is a command edge, and low when the next edge is the half-cycle edge in between.

A command is an active-low load strobe, a read/write select and a word address, all taken on a command edge. The second word of a burst goes to the address with its lowest bit inverted, so a burst always stays inside its aligned pair. Write data is late: it arrives in two beats starting one command cycle after the address, and each beat has its own active-low byte enables. Read data leaves in two beats starting 1.5 command cycles after the address. The bus output enable is high only while those beats are on the bus.

A completed write burst is held in a single posted buffer. It is committed to the array when the next write burst starts to arrive. Reads merge the buffer over the array byte by byte, so every read sees all writes issued before it and none issued after it. A new command can be taken on every command edge in any mix of reads and writes.

Top module: `ddr2_burst_sram_core`

## Requirements
- R1: While reset is active and at the first falling clock edge after it ends, `dq_oe` is 0 and `k_edge` is 1. The first rising edge after reset is a command edge.
- R2: A command edge with `load_n` high is a no-operation. It produces no read beats. The data beats that follow it change no stored byte, even when their byte enables are active.
- R3: For a read taken on command edge n, word `addr` is on `dq_out` with `dq_oe` high after rising edge n+3. Word `addr ^ 1` follows after rising edge n+4.
- R4: For a write taken on command edge n, the word for `addr` is sampled on edge n+2 and the word for `addr ^ 1` on edge n+3.
- R5: `bw_n[i]` low enables lane i, which is bits [9i+8:9i] of the word. The lanes are sampled separately for each beat, and disabled lanes keep their old contents.
- R6: A read returns the data of every write issued before it, including a write on the command edge just before it, merged lane by lane.
- R7: A read issued before a write to the same pair returns the data from before that write.
- R8: `k_edge` alternates on every clock edge. Reads and writes may be issued on consecutive command edges in any mix with no dead cycles.
- R9: `dq_oe` is 0 during every data phase that is not one of the two beats of a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock at twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_edge | output | 1 | High when the next rising edge is a command edge |
| load_n | input | 1 | Active-low command strobe |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word address of the first beat |
| bw_n | input | LANES | Active-low byte-lane write enables for the current beat |
| dq_in | input | LANES*LANE_W | Write data beat |
| dq_out | output | LANES*LANE_W | Read data beat |
| dq_oe | output | 1 | Output enable for the shared data bus |

## Verification
A posted buffer that holds the wrong pair or the wrong lane mask shows up as stale or mixed bytes on `dq_out`. This is seen on the first read that touches the affected pair, three or four edges after that read is issued. A read pipeline that slips by one phase shows up at once: the beats move by one edge, or `dq_oe` rises during the wrong phase. A write to the array that is lost or doubled becomes visible only once the buffer has moved on, which happens after the next write burst begins. For this reason the random mix keeps addresses in a small window, so each pair is read soon after it is committed.

// File: rtl/ddr2_burst_sram_core.sv
module ddr2_burst_sram_core #(
  parameter int AW     = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 4,
  localparam int DW    = LANE_W * LANES,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             k_edge,
  input  logic             load_n,
  input  logic             rd_wr,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] bw_n,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);

  logic [DW-1:0] mem [DEPTH];

  logic          phase;
  logic          wp_v, b2_v;
  logic [AW-1:0] wp_a;
  logic          buf_v;
  logic [AW-1:0] buf_a;
  logic [DW-1:0] buf_w [2];
  logic [LANES-1:0] buf_m [2];
  logic          rq_v, ro_v;
  logic [AW-1:0] rq_a, ro_a;
  logic [AW-1:0] rd_sel;
  logic [DW-1:0] rd_word;

  assign k_edge = ~phase;

  wire take_wr = k_edge & ~load_n & ~rd_wr;
  wire take_rd = k_edge & ~load_n &  rd_wr;
  wire beat1   = k_edge & wp_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_v <= 1'b0;
      wp_a <= '0;
      b2_v <= 1'b0;
    end else begin
      b2_v <= beat1;
      if (k_edge) begin
        wp_v <= take_wr;
        if (take_wr) wp_a <= addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_v    <= 1'b0;
      buf_a    <= '0;
      buf_w[0] <= '0;
      buf_w[1] <= '0;
      buf_m[0] <= '0;
      buf_m[1] <= '0;
    end else if (beat1) begin
      buf_v            <= 1'b1;
      buf_a            <= wp_a;
      buf_w[wp_a[0]]   <= dq_in;
      buf_m[wp_a[0]]   <= ~bw_n;
      buf_m[~wp_a[0]]  <= '0;
    end else if (b2_v) begin
      buf_w[~buf_a[0]] <= dq_in;
      buf_m[~buf_a[0]] <= ~bw_n;
    end
  end

  always_ff @(posedge clk)
    if (beat1 && buf_v)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l < LANES; l++)
          if (buf_m[w][l])
            mem[{buf_a[AW-1:1], w[0]}][l*LANE_W +: LANE_W] <= buf_w[w][l*LANE_W +: LANE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_v <= 1'b0;
      rq_a <= '0;
      ro_v <= 1'b0;
      ro_a <= '0;
    end else if (k_edge) begin
      rq_v <= take_rd;
      if (take_rd) rq_a <= addr;
      ro_v <= rq_v;
      ro_a <= rq_a;
    end
  end

  assign rd_sel = k_edge ? (ro_a ^ AW'(1)) : ro_a;

  always_comb begin
    rd_word = mem[rd_sel];
    if (buf_v && buf_a[AW-1:1] == rd_sel[AW-1:1])
      for (int l = 0; l < LANES; l++)
        if (buf_m[rd_sel[0]][l])
          rd_word[l*LANE_W +: LANE_W] = buf_w[rd_sel[0]][l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe <= ro_v;
      if (ro_v) dq_out <= rd_word;
    end
  end

endmodule

// File: rtl/ddr2_burst_sram_chk.sv
module ddr2_burst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic k_edge,
  input logic load_n,
  input logic rd_wr,
  input logic dq_oe
);

  p_phase_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (k_edge != $past(k_edge)));

  p_read_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(k_edge && !load_n && rd_wr, 4));

  p_burst_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |=> dq_oe);

  p_oe_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> k_edge);

  p_idle_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (k_edge && !$past(k_edge && !load_n && rd_wr, 4)) |-> !dq_oe);

  p_noop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (k_edge && $past(k_edge && load_n, 4)) |-> !dq_oe);

endmodule

bind ddr2_burst_sram_core ddr2_burst_sram_chk u_chk (.*);

// File: tb/ddr2_burst_sram_core_test.sv
module ddr2_burst_sram_core_test;
  localparam int AW = 8, LW = 9, LN = 4, DW = 36;

  logic clk = 1'b0, rst_n = 1'b0;
  logic k_edge, load_n = 1'b1, rd_wr = 1'b1, dq_oe;
  logic [AW-1:0] addr = '0;
  logic [LN-1:0] bw_n = '1;
  logic [DW-1:0] dq_in = '0, dq_out;

  always #2 clk = ~clk;

  ddr2_burst_sram_core uut (.clk(clk), .rst_n(rst_n), .k_edge(k_edge), .load_n(load_n),
    .rd_wr(rd_wr), .addr(addr), .bw_n(bw_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

  int checks = 0, errors = 0, ec = 0;
  always @(posedge clk) ec <= ec + 1;

  logic [DW-1:0] ref_mem [1<<AW];
  logic [DW-1:0] exp_q [$];
  int            when_q [$];
  string         tag_q [$];

  logic [DW-1:0] pd1 = '0, pd2 = '0;
  logic [LN-1:0] pb1 = '0, pb2 = '0;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [LN-1:0] b);
    logic [DW-1:0] r = o;
    for (int l = 0; l < LN; l++) if (!b[l]) r[l*LW +: LW] = n[l*LW +: LW];
    return r;
  endfunction

  function automatic logic [DW-1:0] rnd36();
    return {$urandom(), $urandom()} & {DW{1'b1}};
  endfunction

  task automatic check(input bit ok, input string tag, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", tag, what);
    end
  endtask

  task automatic cmd(input logic ld_n, input logic rw, input logic [AW-1:0] a,
                     input logic [DW-1:0] d1, input logic [LN-1:0] b1,
                     input logic [DW-1:0] d2, input logic [LN-1:0] b2, input string tag);
    logic [DW-1:0] o2;
    logic [LN-1:0] ob2;
    int n;
    @(negedge clk);
    while (!k_edge) @(negedge clk);
    load_n = ld_n; rd_wr = rw; addr = a;
    dq_in = pd1; bw_n = pb1;
    o2 = pd2; ob2 = pb2;
    n = ec + 1;
    if (!ld_n && rw) begin
      exp_q.push_back(ref_mem[a]);       when_q.push_back(n + 3); tag_q.push_back(tag);
      exp_q.push_back(ref_mem[a ^ 1]);   when_q.push_back(n + 4); tag_q.push_back(tag);
    end
    if (!ld_n && !rw) begin
      ref_mem[a]     = merge(ref_mem[a], d1, b1);
      ref_mem[a ^ 1] = merge(ref_mem[a ^ 1], d2, b2);
      pd1 = d1; pb1 = b1; pd2 = d2; pb2 = b2;
    end else begin
      pd1 = rnd36(); pd2 = rnd36(); pb1 = '0; pb2 = '0;
    end
    @(negedge clk);
    dq_in = o2; bw_n = ob2;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d1, input logic [LN-1:0] b1,
                    input logic [DW-1:0] d2, input logic [LN-1:0] b2, input string tag);
    cmd(1'b0, 1'b0, a, d1, b1, d2, b2, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cmd(1'b0, 1'b1, a, '0, '1, '0, '1, tag);
  endtask

  task automatic nop(input int k);
    for (int i = 0; i < k; i++) cmd(1'b1, 1'b1, '0, '0, '1, '0, '1, "R2");
  endtask

  always @(negedge clk) begin
    if (rst_n && dq_oe) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9: dq_oe high with no read due, dq_out=%h expected oe=0", dq_out);
      end else begin
        logic [DW-1:0] e;
        int w;
        string t;
        e = exp_q.pop_front(); w = when_q.pop_front(); t = tag_q.pop_front();
        if (dq_out !== e || ec != w) begin
          errors++;
          $display("FAIL %s: read beat actual %h at edge %0d, expected %h at edge %0d",
                   t, dq_out, ec, e, w);
        end
      end
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    check(dq_oe == 1'b0, "R1", $sformatf("oe in reset actual %b expected 0", dq_oe));
    rst_n = 1'b1;
    check(k_edge == 1'b1 && dq_oe == 1'b0, "R1",
          $sformatf("after reset k_edge/oe actual %b%b expected 10", k_edge, dq_oe));
    @(negedge clk);
    check(k_edge == 1'b0, "R8", $sformatf("k_edge actual %b expected 0", k_edge));

    for (int i = 0; i < 32; i += 2) wr(AW'(i), rnd36(), '0, rnd36(), '0, "R4");
    for (int i = 0; i < 32; i += 2) rd(AW'(i), "R4");
    rd(AW'(5), "R3");
    rd(AW'(12), "R3");
    nop(4);

    wr(AW'(6), rnd36(), 4'b1010, rnd36(), 4'b0101, "R5");
    rd(AW'(7), "R6");
    rd(AW'(6), "R5");
    wr(AW'(10), rnd36(), '1, rnd36(), '1, "R5");
    rd(AW'(10), "R5");
    nop(3);

    rd(AW'(9), "R7");
    wr(AW'(9), rnd36(), 4'b0000, rnd36(), 4'b0110, "R7");
    rd(AW'(8), "R6");
    nop(3);

    cmd(1'b1, 1'b0, AW'(14), rnd36(), '0, rnd36(), '0, "R2");
    cmd(1'b1, 1'b1, AW'(14), '0, '1, '0, '1, "R2");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(!dq_oe, "R2", $sformatf("oe after no-op actual %b expected 0", dq_oe));
    end
    rd(AW'(14), "R2");
    nop(4);
    check(exp_q.size() == 0, "R3", $sformatf("pending beats actual %0d expected 0", exp_q.size()));

    for (int i = 0; i < 400; i++) begin
      int r;
      logic [AW-1:0] a;
      r = $urandom_range(0, 9);
      a = AW'($urandom_range(0, 15));
      if (r < 4)      wr(a, rnd36(), LN'($urandom()), rnd36(), LN'($urandom()), "R6");
      else if (r < 9) rd(a, "R8");
      else            nop(1);
    end
    nop(5);
    check(exp_q.size() == 0, "R8", $sformatf("pending beats actual %0d expected 0", exp_q.size()));
    check(!dq_oe, "R9", $sformatf("oe at end actual %b expected 0", dq_oe));
    summary();
    $finish;
  end
endmodule